// File: doc/BRIEF.md
# Iterative Multiplier with Left-Shift Mode

This unit forms 32 of the 64 bits of a product of two 32-bit operands. It handles the four integer multiply flavours of a 32-bit scalar core: low half, high half with both operands signed, high half with a signed first operand and an unsigned second operand, and high half with both operands unsigned. The same datapath also performs logical left shifts. In shift mode, the second operand's low five bits become a one-hot power of two. The unit multiplies the first operand by that power and keeps the low half of the product, so no barrel shifter is needed.

The core is iterative. A start pulse samples the operands and mode inputs while the unit is idle. The unit then runs one shift-and-add step per clock for 32 clocks, and one clock later it raises a one-cycle done strobe. The result port keeps its value until the next done strobe. Signed operands are reduced to magnitudes before the loop. The 64-bit unsigned product is negated at the end when exactly one signed operand was negative.

Top module: `mulshl_unit`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `result` is 0.
- R2: With `shift_mode`=0 and `take_high`=0, `result` equals bits 31:0 of the product, whatever the signedness flags are.
- R3: With `shift_mode`=0, `take_high`=1 and both flags set, `result` equals bits 63:32 of the product of both operands read as two's complement.
- R4: With `shift_mode`=0, `take_high`=1, `opa_signed`=1 and `opb_signed`=0, `result` equals bits 63:32 of the product of `opa` read as two's complement and `opb` read as unsigned.
- R5: With `shift_mode`=0, `take_high`=1 and both flags clear, `result` equals bits 63:32 of the unsigned product.
- R6: With `shift_mode`=1, `result` equals `opa` shifted left by `opb[4:0]` with zero fill. `opb[31:5]`, `opa_signed`, `opb_signed` and `take_high` have no effect.
- R7: A start sampled at a clock edge while `busy` is 0 sets `busy` from the next cycle. `busy` falls after 32 further edges. `done` is high for exactly one cycle, after the 33rd edge following the accepting edge.
- R8: A start sampled while `busy` is 1 is ignored. The operation in flight completes with its own result, and no extra done strobe follows.
- R9: `result` changes only at an edge that raises `done`, and holds between strobes.
- R10: Operand and mode inputs are sampled only at the accepting edge. Changes to them during the computation do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| opa | input | 32 | First operand (multiplicand / value to shift) |
| opb | input | 32 | Second operand, or shift amount in bits 4:0 |
| opa_signed | input | 1 | Treat `opa` as two's complement |
| opb_signed | input | 1 | Treat `opb` as two's complement |
| take_high | input | 1 | Return bits 63:32 instead of 31:0 |
| shift_mode | input | 1 | Perform a logical left shift |
| busy | output | 1 | Computation in progress; starts ignored |
| done | output | 1 | One-cycle strobe: `result` is new |
| result | output | 32 | Selected half of the product, held |

## Verification
The four multiply flavours are run with small positive values, mixed-sign values, the most negative operand against itself and against -1, and all-ones operands. These patterns separate the signed, mixed and unsigned high halves, which differ only when a sign bit is set. Shifts use amounts of 0, 4 and 31, and an operand whose upper bits and mode flags are set. These show that only `opb[4:0]` counts and that the flags are overridden. Operands that change in mid-flight and a start raised while busy show that inputs are sampled once and that a running job cannot be interrupted. A reference model compares `busy`, `done` and `result` at every clock.

// File: rtl/mulshl_pkg.sv
package mulshl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

endpackage

// File: rtl/mulshl_prep.sv
module mulshl_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         a_signed_i,
    input  logic         b_signed_i,
    input  logic         shift_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_o
);
    localparam int SH_W = $clog2(W);

    logic a_neg;
    logic b_neg;
    logic [SH_W-1:0] amt;

    always_comb begin
        amt   = b_i[SH_W-1:0];
        a_neg = a_signed_i & a_i[W-1] & ~shift_i;
        b_neg = b_signed_i & b_i[W-1] & ~shift_i;
        mag_a_o = a_neg ? (~a_i + W'(1)) : a_i;
        if (shift_i) begin
            mag_b_o = W'(1) << amt;
        end else begin
            mag_b_o = b_neg ? (~b_i + W'(1)) : b_i;
        end
        neg_o = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mulshl_core.sv
module mulshl_core
    import mulshl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplr_i,
    input  logic           neg_i,
    input  logic           hi_i,
    output logic           busy_o,
    output logic           fin_o,
    output logic [2*W-1:0] prod_o,
    output logic           neg_o,
    output logic           hi_o
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] acc;
        logic [PW-1:0] mcand;
        logic [W-1:0]  mplr;
        logic [CW-1:0] cnt;
        logic          neg;
        logic          hi;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_RUN: begin
                if (st_q.mplr[0]) begin
                    st_d.acc = st_q.acc + st_q.mcand;
                end
                st_d.mcand = st_q.mcand << 1;
                st_d.mplr  = st_q.mplr >> 1;
                st_d.cnt   = st_q.cnt - CW'(1);
                if (st_q.cnt == CW'(1)) begin
                    st_d.ph = PH_FIN;
                end
            end
            default: begin
                if (st_q.ph == PH_FIN) begin
                    st_d.ph = PH_IDLE;
                end
                if (load_i) begin
                    st_d.ph    = PH_RUN;
                    st_d.acc   = '0;
                    st_d.mcand = {{W{1'b0}}, mcand_i};
                    st_d.mplr  = mplr_i;
                    st_d.cnt   = CW'(W);
                    st_d.neg   = neg_i;
                    st_d.hi    = hi_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, acc: '0, mcand: '0, mplr: '0, cnt: '0, neg: 1'b0, hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.ph == PH_RUN);
    assign fin_o  = (st_q.ph == PH_FIN);
    assign prod_o = st_q.acc;
    assign neg_o  = st_q.neg;
    assign hi_o   = st_q.hi;

    // R7
    last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && st_q.cnt == CW'(1)) |=> (st_q.ph == PH_FIN));

    // R7
    run_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN) |-> (st_q.cnt != '0));

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && st_q.cnt != CW'(1)) |=> (st_q.ph == PH_RUN && st_q.cnt == $past(st_q.cnt) - CW'(1)));
endmodule

// File: rtl/mulshl_finish.sv
module mulshl_finish #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic           neg_i,
    input  logic           hi_i,
    output logic [W-1:0]   res_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] fixed;

    always_comb begin
        fixed = neg_i ? (~prod_i + PW'(1)) : prod_i;
        res_o = hi_i ? fixed[PW-1:W] : fixed[W-1:0];
    end
endmodule

// File: rtl/mulshl_unit.sv
module mulshl_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         opa_signed,
    input  logic         opb_signed,
    input  logic         take_high,
    input  logic         shift_mode,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic         done;
        logic [W-1:0] res;
    } out_st_t;

    out_st_t o_d, o_q;

    logic [W-1:0]  mag_a, mag_b;
    logic          neg_in;
    logic          load;
    logic          core_busy, core_fin, core_neg, core_hi;
    logic [PW-1:0] core_prod;
    logic [W-1:0]  fin_res;

    assign load = start & ~core_busy;

    mulshl_prep #(.W(W)) u_prep (
        .a_i        (opa),
        .b_i        (opb),
        .a_signed_i (opa_signed),
        .b_signed_i (opb_signed),
        .shift_i    (shift_mode),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_o      (neg_in)
    );

    mulshl_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .mcand_i (mag_a),
        .mplr_i  (mag_b),
        .neg_i   (neg_in),
        .hi_i    (take_high & ~shift_mode),
        .busy_o  (core_busy),
        .fin_o   (core_fin),
        .prod_o  (core_prod),
        .neg_o   (core_neg),
        .hi_o    (core_hi)
    );

    mulshl_finish #(.W(W)) u_finish (
        .prod_i (core_prod),
        .neg_i  (core_neg),
        .hi_i   (core_hi),
        .res_o  (fin_res)
    );

    always_comb begin
        o_d      = o_q;
        o_d.done = core_fin;
        if (core_fin) begin
            o_d.res = fin_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '{done: 1'b0, res: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign busy   = core_busy;
    assign done   = o_q.done;
    assign result = o_q.res;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy, 2) && !$past(busy)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R6
    shift_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && shift_mode) |-> ($countones(mag_b) == 1 && !neg_in));
endmodule

// File: tb/tb_mulshl_unit.sv
`timescale 1ns/1ps
module tb_mulshl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        opa_signed = 1'b0, opb_signed = 1'b0, take_high = 1'b0, shift_mode = 1'b0;
    logic        busy, done;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    mulshl_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .opa_signed(opa_signed), .opb_signed(opb_signed), .take_high(take_high),
        .shift_mode(shift_mode), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [31:0] ref_fn(logic [31:0] a, logic [31:0] b,
                                           logic as, logic bs, logic hi, logic sh);
        logic signed [32:0] x, y;
        logic signed [65:0] p;
        if (sh) return a << b[4:0];
        x = {as & a[31], a};
        y = {bs & b[31], b};
        p = x * y;
        return hi ? p[63:32] : p[31:0];
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_left = 0;
    logic        m_done = 1'b0;
    logic [31:0] m_res = '0, m_pend = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_left = 0; m_done = 1'b0; m_res = '0;
        end else begin
            m_done = 1'b0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_done = 1'b1;
                    m_res = m_pend;
                end
            end
            if (start && m_left == 0) begin
                m_left = 33;
                m_pend = ref_fn(opa, opb, opa_signed, opb_signed, take_high, shift_mode);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "model busy", {31'b0, busy}, {31'b0, m_left >= 2});
            check(cur_req, "model done", {31'b0, done}, {31'b0, m_done});
            check(cur_req, "model result", result, m_res);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic set_in(logic [31:0] a, logic [31:0] b, logic as, logic bs, logic hi, logic sh);
        opa = a; opb = b; opa_signed = as; opb_signed = bs; take_high = hi; shift_mode = sh;
    endtask

    // launch, wait for done, check latency and value
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b,
                          logic as, logic bs, logic hi, logic sh);
        int n;
        logic [31:0] exp;
        exp = ref_fn(a, b, as, bs, hi, sh);
        cur_req = req;
        @(negedge clk);
        set_in(a, b, as, bs, hi, sh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R7", "edges to done", n - 1, 33);
        check(req, "result", result, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", {31'b0, done}, 32'd0);
        check("R1", "busy", {31'b0, busy}, 32'd0);
        check("R1", "result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "result after release", result, 32'd0);

        // R2: low half
        run_op("R2", 32'h1234_5678, 32'h9abc_def0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_op("R2", 32'hffff_fffd, 32'h0000_0005, 1'b1, 1'b1, 1'b0, 1'b0);
        run_op("R2", 32'h0000_0000, 32'hdead_beef, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3: signed x signed high
        run_op("R3", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
        run_op("R3", 32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b1, 1'b1, 1'b0);
        run_op("R3", 32'hffff_fff9, 32'h0000_0003, 1'b1, 1'b1, 1'b1, 1'b0);
        run_op("R3", 32'h8000_0000, 32'hffff_ffff, 1'b1, 1'b1, 1'b1, 1'b0);
        // R4: signed x unsigned high
        run_op("R4", 32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op("R4", 32'h7fff_ffff, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
        // R5: unsigned high
        run_op("R5", 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op("R5", 32'h8000_0000, 32'h0000_0003, 1'b0, 1'b0, 1'b1, 1'b0);
        // R6: shifts
        run_op("R6", 32'h0000_00f1, 32'h0000_0004, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op("R6", 32'h0000_0003, 32'h0000_001f, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op("R6", 32'hcafe_babe, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op("R6", 32'h8765_4321, 32'hffff_ffe3, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R6", "upper bits and flags ignored", result, 32'h3b2a_1908);

        // R10: inputs changed mid-flight
        cur_req = "R10";
        @(negedge clk);
        set_in(32'h0000_1111, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        set_in(32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (40) begin
            @(negedge clk);
            if (done) check("R10", "sampled-once result", result, 32'h0001_1110);
        end

        // R8: start while busy is ignored
        begin
            int pulses = 0;
            cur_req = "R8";
            @(negedge clk);
            set_in(32'h0000_0007, 32'h0000_0009, 1'b0, 1'b0, 1'b0, 1'b0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            set_in(32'h0000_0100, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 60; i++) begin
                if (done) begin
                    pulses++;
                    check("R8", "in-flight result", result, 32'd63);
                end
                @(negedge clk);
            end
            check("R8", "done pulses", pulses, 1);
            // R9: result held afterwards
            check("R9", "held result", result, 32'd63);
        end

        // R7: back-to-back, start in the done cycle
        cur_req = "R7";
        @(negedge clk);
        set_in(32'h0000_0005, 32'h0000_0006, 1'b0, 1'b0, 1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R7", "first of pair", result, 32'd30);
        set_in(32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "busy after accept in done cycle", {31'b0, busy}, 32'd1);
        while (!done) @(negedge clk);
        check("R7", "second of pair", result, 32'd6);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule